// File: doc/BRIEF.md
# Multiplexed VFD Grid Dimming Timer

This block produces the time-multiplexed drive for a vacuum fluorescent display with two or three grids. A free-running oscillator enable is divided into bit times, and bit times are grouped into grid slots. Each slot gives one grid its turn, and the grids take their turns in order. The grid outputs are active low. During a slot, the segment outputs show the data word held for the grid whose turn it is.

Brightness is set by a dimming value. At the start of every slot the segments are switched on, and they are switched off once the slot position reaches the dimming value. The grid itself is on for the whole slot apart from a short gap at its end, so the dimming value is capped at the length of that on-phase.

A select input chooses two grids or three. A change to it takes effect only when the current display cycle ends. A blank input and a sleep input both force the segments dark. Sleep also freezes the timing.

Top module: `vfd_grid_dimmer`

## Requirements
- R1: While reset is high and one cycle after it, grid_n equals 3'b110 (grid 1 active, grids 2 and 3 inactive) and every segment output is low when dim_val is 0.
- R2: A bit time lasts PRESC clock cycles on which osc_en is high and sleep is low. Cycles with osc_en low do not advance the timing.
- R3: A grid slot lasts 2**DIM_W bit times. The active grid steps 1, 2, 3, 1 in three-grid mode and 1, 2, 1 in two-grid mode. grid_n bit k is low only for grid k+1.
- R4: A grid is driven active (its grid_n bit low) for the first 2**DIM_W-GAP bit times of its slot. For the last GAP bit times, grid_n is 3'b111.
- R5: Segments may light only while the bit position inside the slot is below the effective duty. A duty of 0 keeps them dark for the whole slot.
- R6: A dim_val above 2**DIM_W-GAP acts as exactly 2**DIM_W-GAP.
- R7: While the duty window is open, seg_out bit i equals bit i of the data word (seg_g1, seg_g2 or seg_g3) for the active grid.
- R8: blank_n low forces seg_out to zero, and the grid sequence keeps running.
- R9: duplex_sel low selects three grids and duplex_sel high selects two grids. In two-grid mode, grid_n[2] stays high.
- R10: duplex_sel is sampled at reset and at the end of each display cycle. A change between those points does not alter the current cycle.
- R11: While sleep is high the timing stands still and seg_out is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | Oscillator clock enable, one pulse per oscillator period |
| sleep | input | 1 | Freezes timing and darkens segments |
| duplex_sel | input | 1 | 1 = two grids, 0 = three grids |
| blank_n | input | 1 | Low forces all segments off |
| dim_val | input | DIM_W | Dimming duty in bit times per slot |
| seg_g1 | input | SEG_W | Segment data for grid 1 |
| seg_g2 | input | SEG_W | Segment data for grid 2 |
| seg_g3 | input | SEG_W | Segment data for grid 3 |
| grid_n | output | 3 | Active-low grid enables, bit 0 = grid 1 |
| seg_out | output | SEG_W | Segment outputs |

## Verification
The assertions assume that duplex_sel, blank_n, sleep and dim_val are synchronous to clk. They also assume those inputs hold steady across each active edge, so a mode change is seen cleanly at a cycle boundary.

The stimulus changes every input only on the falling edge of the clock. It moves duplex_sel at points that are deliberately not cycle boundaries, so the deferred-switch behaviour is exercised. The duty sweep covers every dimming code of a reduced configuration, including all codes that saturate. The enable pattern stalls the prescaler at irregular phases.

// File: rtl/vfd_dim_pkg.sv
package vfd_dim_pkg;

    typedef enum logic [1:0] {
        GRID_1 = 2'd0,
        GRID_2 = 2'd1,
        GRID_3 = 2'd2
    } grid_sel_t;

    typedef enum logic {
        SCAN_TRIPLE = 1'b0,
        SCAN_DOUBLE = 1'b1
    } scan_mode_t;

    typedef struct packed {
        logic grid_on;
        logic win_open;
    } slot_phase_t;

    function automatic grid_sel_t last_grid(input scan_mode_t m);
        return (m == SCAN_DOUBLE) ? GRID_2 : GRID_3;
    endfunction

    function automatic logic [2:0] grid_drive_n(input grid_sel_t g, input logic on);
        logic [2:0] v;
        v = 3'b111;
        if (on) v[g] = 1'b0;
        return v;
    endfunction

endpackage

// File: rtl/vfd_bit_prescaler.sv
module vfd_bit_prescaler #(
    parameter int PRESC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic osc_en,
    input  logic sleep,
    output logic bit_tick
);
    localparam int CW = (PRESC > 1) ? $clog2(PRESC) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(PRESC - 1);

    logic [CW-1:0] cnt;
    logic          step;

    assign step     = osc_en && !sleep;
    assign bit_tick = step && (cnt == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst)           cnt <= '0;
        else if (bit_tick) cnt <= '0;
        else if (step)     cnt <= cnt + 1'b1;
    end

    a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_LAST);

    a_r2_stall: assert property (@(posedge clk) disable iff (rst)
        !osc_en |=> $stable(cnt));

endmodule

// File: rtl/vfd_grid_sequencer.sv
module vfd_grid_sequencer
    import vfd_dim_pkg::*;
#(
    parameter int DIM_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_tick,
    input  logic             duplex_sel,
    output logic [DIM_W-1:0] slot_pos,
    output grid_sel_t        grid,
    output scan_mode_t       mode
);
    localparam logic [DIM_W-1:0] POS_LAST = '1;

    logic slot_end;
    logic cyc_end;

    assign slot_end = bit_tick && (slot_pos == POS_LAST);
    assign cyc_end  = slot_end && (grid == last_grid(mode));

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_pos <= '0;
            grid     <= GRID_1;
            mode     <= scan_mode_t'(duplex_sel);
        end else if (bit_tick) begin
            slot_pos <= slot_pos + 1'b1;
            if (cyc_end) begin
                grid <= GRID_1;
                mode <= scan_mode_t'(duplex_sel);
            end else if (slot_end) begin
                grid <= grid_sel_t'(grid + 2'd1);
            end
        end
    end

    a_r3_grid_steps: assert property (@(posedge clk) disable iff (rst)
        ($past(slot_pos) == POS_LAST && slot_pos == '0) |-> grid != $past(grid));

    a_r3_grid_holds: assert property (@(posedge clk) disable iff (rst)
        (slot_pos != '0) |-> grid == $past(grid));

    a_r9_no_third: assert property (@(posedge clk) disable iff (rst)
        (mode == SCAN_DOUBLE) |-> grid != GRID_3);

    a_r10_mode_at_wrap: assert property (@(posedge clk) disable iff (rst)
        (mode != $past(mode)) |-> (grid == GRID_1 && slot_pos == '0));

endmodule

// File: rtl/vfd_duty_window.sv
module vfd_duty_window
    import vfd_dim_pkg::*;
#(
    parameter int DIM_W = 10,
    parameter int GAP   = 8
) (
    input  logic [DIM_W-1:0] slot_pos,
    input  logic [DIM_W-1:0] dim_val,
    output slot_phase_t      phase
);
    localparam int               SLOT    = 1 << DIM_W;
    localparam logic [DIM_W-1:0] ACT_LIM = DIM_W'(SLOT - GAP);

    logic [DIM_W-1:0] duty_eff;

    always_comb begin
        duty_eff       = (dim_val > ACT_LIM) ? ACT_LIM : dim_val;
        phase.grid_on  = slot_pos < ACT_LIM;
        phase.win_open = slot_pos < duty_eff;
    end

    always_comb begin
        a_r6_window_in_grid: assert (!phase.win_open || phase.grid_on);
    end

endmodule

// File: rtl/vfd_grid_dimmer.sv
module vfd_grid_dimmer
    import vfd_dim_pkg::*;
#(
    parameter int PRESC = 4,
    parameter int DIM_W = 10,
    parameter int GAP   = 8,
    parameter int SEG_W = 82
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             osc_en,
    input  logic             sleep,
    input  logic             duplex_sel,
    input  logic             blank_n,
    input  logic [DIM_W-1:0] dim_val,
    input  logic [SEG_W-1:0] seg_g1,
    input  logic [SEG_W-1:0] seg_g2,
    input  logic [SEG_W-1:0] seg_g3,
    output logic [2:0]       grid_n,
    output logic [SEG_W-1:0] seg_out
);
    logic             bit_tick;
    logic [DIM_W-1:0] slot_pos;
    grid_sel_t        grid;
    scan_mode_t       mode;
    slot_phase_t      phase;
    logic             seg_gate;

    vfd_bit_prescaler #(.PRESC(PRESC)) presc_i (
        .clk     (clk),
        .rst     (rst),
        .osc_en  (osc_en),
        .sleep   (sleep),
        .bit_tick(bit_tick)
    );

    vfd_grid_sequencer #(.DIM_W(DIM_W)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .bit_tick  (bit_tick),
        .duplex_sel(duplex_sel),
        .slot_pos  (slot_pos),
        .grid      (grid),
        .mode      (mode)
    );

    vfd_duty_window #(.DIM_W(DIM_W), .GAP(GAP)) duty_i (
        .slot_pos(slot_pos),
        .dim_val (dim_val),
        .phase   (phase)
    );

    assign grid_n   = grid_drive_n(grid, phase.grid_on);
    assign seg_gate = phase.win_open && blank_n && !sleep;

    for (genvar i = 0; i < SEG_W; i++) begin : g_seg
        always_comb begin
            unique case (grid)
                GRID_1:  seg_out[i] = seg_gate && seg_g1[i];
                GRID_2:  seg_out[i] = seg_gate && seg_g2[i];
                default: seg_out[i] = seg_gate && seg_g3[i];
            endcase
        end
    end

    a_r3_one_grid: assert property (@(posedge clk) disable iff (rst)
        $countones(~grid_n) <= 1);

    a_r4_dark_in_gap: assert property (@(posedge clk) disable iff (rst)
        (grid_n == 3'b111) |-> seg_out == '0);

    a_r8_blank: assert property (@(posedge clk) disable iff (rst)
        !blank_n |-> seg_out == '0);

    a_r11_freeze: assert property (@(posedge clk) disable iff (rst)
        sleep |=> ($stable(slot_pos) && $stable(grid)));

    a_r5_zero_duty: assert property (@(posedge clk) disable iff (rst)
        (dim_val == '0) |-> seg_out == '0);

endmodule

// File: tb/vfd_grid_dimmer_tb_top.sv
module vfd_grid_dimmer_tb_top;
    localparam int PRESC = 2;
    localparam int DIM_W = 5;
    localparam int GAP   = 2;
    localparam int SEG_W = 8;
    localparam int SLOT  = 1 << DIM_W;
    localparam int ACT   = SLOT - GAP;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             osc_en = 1'b1;
    logic             sleep = 1'b0;
    logic             duplex_sel = 1'b0;
    logic             blank_n = 1'b1;
    logic [DIM_W-1:0] dim_val = '0;
    logic [SEG_W-1:0] seg_g1 = 8'hA5;
    logic [SEG_W-1:0] seg_g2 = 8'h3C;
    logic [SEG_W-1:0] seg_g3 = 8'hF1;
    logic [2:0]       grid_n;
    logic [SEG_W-1:0] seg_out;

    int    errors = 0;
    int    checks = 0;
    string tag_g  = "R3";
    string tag_s  = "R7";

    // reference: enabled cycles counted inside the current display cycle
    int   m_n = 0;
    logic m_dup = 1'b0;

    always #10 clk = ~clk;

    vfd_grid_dimmer #(.PRESC(PRESC), .DIM_W(DIM_W), .GAP(GAP), .SEG_W(SEG_W)) dut_i (
        .clk(clk), .rst(rst), .osc_en(osc_en), .sleep(sleep),
        .duplex_sel(duplex_sel), .blank_n(blank_n), .dim_val(dim_val),
        .seg_g1(seg_g1), .seg_g2(seg_g2), .seg_g3(seg_g3),
        .grid_n(grid_n), .seg_out(seg_out)
    );

    function automatic int cyc_len(input logic dup);
        return PRESC * SLOT * (dup ? 2 : 3);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_n   <= 0;
            m_dup <= duplex_sel;
        end else if (osc_en && !sleep) begin
            if (m_n == cyc_len(m_dup) - 1) begin
                m_n   <= 0;
                m_dup <= duplex_sel;
            end else begin
                m_n <= m_n + 1;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always begin
        @(posedge clk);
        #15;
        if (!rst) begin
            int bits, pos, g, duty;
            logic [2:0] eg;
            logic [SEG_W-1:0] es, word;
            string tg;
            bits = m_n / PRESC;
            pos  = bits % SLOT;
            g    = bits / SLOT;
            duty = (int'(dim_val) > ACT) ? ACT : int'(dim_val);
            eg   = 3'b111;
            if (pos < ACT) eg[g] = 1'b0;
            word = (g == 0) ? seg_g1 : (g == 1) ? seg_g2 : seg_g3;
            es   = (pos < duty && blank_n && !sleep) ? word : '0;
            tg   = tag_g;
            if (tg == "R3" && m_dup) tg = "R9";
            else if (tg == "R3" && pos >= ACT) tg = "R4";
            check(tg, 32'(grid_n), 32'(eg));
            check(tag_s, 32'(seg_out), 32'(es));
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", 32'(grid_n), 32'h6);
        check("R1", 32'(seg_out), 32'h0);
        rst = 1'b0;

        // R5 / R6: every duty code, one triplex cycle each
        for (int d = 0; d < SLOT; d++) begin
            @(negedge clk);
            dim_val = DIM_W'(d);
            tag_s = (d > ACT) ? "R6" : "R5";
            seg_g1 = 8'(d * 37 + 1);
            seg_g2 = ~seg_g1;
            seg_g3 = 8'(d * 11 + 90);
            repeat (3 * SLOT * PRESC - 1) @(negedge clk);
        end

        // R7: full duty, varied data
        tag_s = "R7";
        dim_val = '1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            seg_g1 = 8'(1 << k);
            seg_g2 = 8'(8'hFF >> k);
            seg_g3 = 8'(k * 29);
            repeat (70) @(negedge clk);
        end

        // R2: irregular enable pattern stalls the prescaler
        tag_g = "R2";
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            osc_en = (k % 3 != 0) && (k % 7 != 2);
        end
        @(negedge clk);
        osc_en = 1'b1;

        // R8: blank keeps segments dark, grids run on
        tag_g = "R3";
        tag_s = "R8";
        blank_n = 1'b0;
        repeat (250) @(negedge clk);
        blank_n = 1'b1;

        // R11: sleep freezes timing and darkens segments
        tag_g = "R11";
        tag_s = "R11";
        sleep = 1'b1;
        repeat (60) @(negedge clk);
        sleep = 1'b0;
        tag_g = "R3";
        tag_s = "R7";
        repeat (40) @(negedge clk);

        // R10 / R9: switch to two grids mid-cycle, later back
        tag_g = "R10";
        duplex_sel = 1'b1;
        repeat (3 * SLOT * PRESC + 2 * 2 * SLOT * PRESC) @(negedge clk);
        duplex_sel = 1'b0;
        repeat (2 * SLOT * PRESC + 3 * SLOT * PRESC + 20) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule